// File: doc/BRIEF.md
# Interrupt Line Capture and Pending Logic

This block sits between a set of external interrupt wires and the arbitration stage of an interrupt distributor. It samples each wire through a synchronizer, remembers the last level it accepted for that wire, and keeps one pending bit per source per processor. Software-visible configuration arrives as plain vectors: an enable bit per source, a two-bit mode field per source, and a processor target mask per source. The arbitration stage reads the pending array and never writes it.

Two events come back from the processors. An acknowledge, carrying a processor number and an interrupt ID, retires pending state. An end-of-interrupt, carrying the same pair, gives a level-triggered source that is still asserted a fresh pending bit for that processor. The per-source handling model decides whether one acknowledge retires the source for every processor or only for the one that took it. Picking a winner by priority is not done here.

Top module: `irq_line_pending`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every pending bit is 0 and every stored line level is 0.
- R2: Each external wire passes through a two-stage synchronizer. A level applied before rising clock edge k is first acted on at edge k+2, so pending_o shows it after the third edge.
- R3: External wire n is interrupt ID n+32. An acknowledge or end-of-interrupt whose ID is not in 32 to 32+NUM_LINES-1 changes nothing.
- R4: When a source's synchronized level goes from 0 to 1, its stored level becomes 1. If the source is edge-triggered or enabled, its pending bit is set for every processor in its target mask. Otherwise only the level is recorded.
- R5: A synchronized level equal to the stored level causes no action. A wire held high does not pend again after an acknowledge.
- R6: When a source's synchronized level goes from 1 to 0, only the stored level is cleared. No pending bit changes.
- R7: When the model bit is 1 (single handler), an acknowledge of the source clears its pending bit for all processors.
- R8: When the model bit is 0 (every target handles it), an acknowledge clears the pending bit only for the acknowledging processor.
- R9: An end-of-interrupt from processor c for a source sets that source's pending bit for c only if four conditions hold: the source is level-triggered, it is enabled, its stored level is 1, and c is in its target mask. Otherwise the end-of-interrupt does nothing.
- R10: Source n's mode field is `src_mode_i[2n+1:2n]`. Bit 2n is the model (1 = single handler) and bit 2n+1 is the trigger (1 = edge, 0 = level).
- R11: If a set (line rise or end-of-interrupt) and an acknowledge clear hit the same pending bit in the same cycle, the bit ends set.
- R12: Source n's target mask is `src_target_i[n*NUM_CPU +: NUM_CPU]`, and bit c selects processor c. Pending bit (n, c) appears on `pending_o[n*NUM_CPU + c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | NUM_LINES | Asynchronous external interrupt wires |
| src_enable_i | input | NUM_LINES | Per-source enable |
| src_mode_i | input | 2*NUM_LINES | Per-source {trigger, model} field |
| src_target_i | input | NUM_LINES*NUM_CPU | Per-source processor target masks |
| ack_valid_i | input | 1 | Acknowledge event strobe |
| ack_cpu_i | input | CPU_W | Acknowledging processor |
| ack_id_i | input | 10 | Acknowledged interrupt ID |
| eoi_valid_i | input | 1 | End-of-interrupt event strobe |
| eoi_cpu_i | input | CPU_W | Processor signalling end-of-interrupt |
| eoi_id_i | input | 10 | Interrupt ID being completed |
| pending_o | output | NUM_LINES*NUM_CPU | Pending bit per source per processor |

## Verification
The bench aims at the acknowledge that lands on the same edge as a rising line. A design that put the clear after the set would lose that interrupt. It also checks that a wire held high does not pend again after an acknowledge. An edge detector that looks at the level instead of the transition would keep re-pending it. End-of-interrupt is exercised against edge sources, deasserted level sources and processors outside the target mask. A design that ignores any one of those four conditions would show a pending bit that should not be there. IDs just outside the window, and raw wire numbers used without the offset of 32, check that a design with the wrong offset or an unbounded decode would clear the wrong source.

// File: rtl/irq_line_pending_pkg.sv
package irq_line_pending_pkg;

    // Width of interrupt IDs carried by acknowledge and end-of-interrupt events
    localparam int IRQ_ID_W    = 10;
    // ID assigned to external wire 0
    localparam int EXT_ID_BASE = 32;

    // Outcome of comparing a synchronized wire against its stored level
    typedef enum logic [1:0] {
        LN_HOLD = 2'd0,
        LN_RISE = 2'd1,
        LN_FALL = 2'd2
    } line_evt_e;

    // Two-bit per-source mode field: upper bit trigger, lower bit model
    typedef struct packed {
        logic edge_trig;    // 1: edge-triggered, 0: level-triggered
        logic one_handler;  // 1: a single processor handles the source
    } src_mode_t;

    // True when an event ID names external source src
    function automatic logic id_hits(input logic [IRQ_ID_W-1:0] id,
                                     input int unsigned src);
        return id == IRQ_ID_W'(EXT_ID_BASE + src);
    endfunction

endpackage

// File: rtl/irq_line_pending_sync.sv
module irq_line_pending_sync #(
    parameter int WIDTH       = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_line_pending_track.sv
module irq_line_pending_track
    import irq_line_pending_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    output logic      level_q,
    output line_evt_e evt_o
);
    // Transition against the last accepted level; equal levels do nothing
    always_comb begin
        if (sync_i == level_q) begin
            evt_o = LN_HOLD;
        end else if (sync_i) begin
            evt_o = LN_RISE;
        end else begin
            evt_o = LN_FALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= sync_i;
        end
    end
endmodule

// File: rtl/irq_line_pending_cell.sv
module irq_line_pending_cell
    import irq_line_pending_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  line_evt_e          evt_i,
    input  src_mode_t          mode_i,
    input  logic               enable_i,
    input  logic [NUM_CPU-1:0] target_i,
    input  logic               level_i,
    input  logic               ack_hit_i,
    input  logic [CPU_W-1:0]   ack_cpu_i,
    input  logic               eoi_hit_i,
    input  logic [CPU_W-1:0]   eoi_cpu_i,
    output logic [NUM_CPU-1:0] pend_o
);
    logic [NUM_CPU-1:0] ack_sel;
    logic [NUM_CPU-1:0] eoi_sel;
    logic [NUM_CPU-1:0] set_v;
    logic [NUM_CPU-1:0] clr_v;

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            ack_sel[c] = (ack_cpu_i == CPU_W'(c));
            eoi_sel[c] = (eoi_cpu_i == CPU_W'(c));
        end

        set_v = '0;
        if (evt_i == LN_RISE && (mode_i.edge_trig || enable_i)) begin
            set_v = set_v | target_i;
        end
        if (eoi_hit_i && !mode_i.edge_trig && enable_i && level_i) begin
            set_v = set_v | (eoi_sel & target_i);
        end

        clr_v = '0;
        if (ack_hit_i) begin
            clr_v = mode_i.one_handler ? {NUM_CPU{1'b1}} : ack_sel;
        end
    end

    // Clear first, then set: a coincident set survives
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_v) | set_v;
        end
    end
endmodule

// File: rtl/irq_line_pending.sv
module irq_line_pending
    import irq_line_pending_pkg::*;
#(
    parameter  int NUM_LINES   = 16,
    parameter  int NUM_CPU     = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         irq_line_i,
    input  logic [NUM_LINES-1:0]         src_enable_i,
    input  logic [2*NUM_LINES-1:0]       src_mode_i,
    input  logic [NUM_LINES*NUM_CPU-1:0] src_target_i,
    input  logic                         ack_valid_i,
    input  logic [CPU_W-1:0]             ack_cpu_i,
    input  logic [IRQ_ID_W-1:0]          ack_id_i,
    input  logic                         eoi_valid_i,
    input  logic [CPU_W-1:0]             eoi_cpu_i,
    input  logic [IRQ_ID_W-1:0]          eoi_id_i,
    output logic [NUM_LINES*NUM_CPU-1:0] pending_o
);
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] level_q;
    logic [NUM_LINES-1:0] rise_v;
    logic [NUM_LINES-1:0] fall_v;
    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] eoi_hit;
    line_evt_e            evt [NUM_LINES];

    irq_line_pending_sync #(
        .WIDTH       (NUM_LINES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_line_i),
        .sync_o  (line_sync)
    );

    for (genvar s = 0; s < NUM_LINES; s++) begin : g_src
        src_mode_t mode_s;
        assign mode_s = src_mode_t'(src_mode_i[2*s +: 2]);

        irq_line_pending_track u_track (
            .clk     (clk),
            .rst     (rst),
            .sync_i  (line_sync[s]),
            .level_q (level_q[s]),
            .evt_o   (evt[s])
        );

        assign rise_v[s]  = (evt[s] == LN_RISE);
        assign fall_v[s]  = (evt[s] == LN_FALL);
        assign ack_hit[s] = ack_valid_i && id_hits(ack_id_i, s);
        assign eoi_hit[s] = eoi_valid_i && id_hits(eoi_id_i, s);

        irq_line_pending_cell #(
            .NUM_CPU (NUM_CPU),
            .CPU_W   (CPU_W)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .evt_i     (evt[s]),
            .mode_i    (mode_s),
            .enable_i  (src_enable_i[s]),
            .target_i  (src_target_i[s*NUM_CPU +: NUM_CPU]),
            .level_i   (level_q[s]),
            .ack_hit_i (ack_hit[s]),
            .ack_cpu_i (ack_cpu_i),
            .eoi_hit_i (eoi_hit[s]),
            .eoi_cpu_i (eoi_cpu_i),
            .pend_o    (pending_o[s*NUM_CPU +: NUM_CPU])
        );
    end
endmodule

// File: rtl/irq_line_pending_chk.sv
module irq_line_pending_chk
    import irq_line_pending_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CPU   = 4,
    parameter int CPU_W     = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_LINES*NUM_CPU-1:0] pending_o,
    input logic [NUM_LINES-1:0]         src_enable_i,
    input logic [2*NUM_LINES-1:0]       src_mode_i,
    input logic [NUM_LINES*NUM_CPU-1:0] src_target_i,
    input logic                         ack_valid_i,
    input logic [CPU_W-1:0]             ack_cpu_i,
    input logic [IRQ_ID_W-1:0]          ack_id_i,
    input logic                         eoi_valid_i,
    input logic [CPU_W-1:0]             eoi_cpu_i,
    input logic [IRQ_ID_W-1:0]          eoi_id_i,
    input logic [NUM_LINES-1:0]         level_q,
    input logic [NUM_LINES-1:0]         rise_v,
    input logic [NUM_LINES-1:0]         fall_v
);
    AST_NO_UNCAUSED_SET: assert property (@(posedge clk) disable iff (rst)
        (!(|rise_v) && !eoi_valid_i) |=> ((pending_o & ~$past(pending_o)) == '0)); // R4

    for (genvar s = 0; s < NUM_LINES; s++) begin : g_chk
        logic a_hit, e_hit, one_h, edge_t;
        assign a_hit  = ack_valid_i && id_hits(ack_id_i, s);
        assign e_hit  = eoi_valid_i && id_hits(eoi_id_i, s);
        assign one_h  = src_mode_i[2*s];
        assign edge_t = src_mode_i[2*s+1];

        AST_SINGLE_HANDLER_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (a_hit && one_h && !rise_v[s] && !e_hit)
            |=> (pending_o[s*NUM_CPU +: NUM_CPU] == '0)); // R7

        AST_PER_CPU_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (a_hit && !one_h && !rise_v[s] && !e_hit && int'(ack_cpu_i) < NUM_CPU)
            |=> !pending_o[s*NUM_CPU + int'($past(ack_cpu_i))]); // R8

        AST_FALL_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
            (fall_v[s] && !a_hit && !e_hit)
            |=> $stable(pending_o[s*NUM_CPU +: NUM_CPU])); // R6

        AST_EOI_REPEND: assert property (@(posedge clk) disable iff (rst)
            (e_hit && !edge_t && src_enable_i[s] && level_q[s] && int'(eoi_cpu_i) < NUM_CPU
             && src_target_i[s*NUM_CPU + int'(eoi_cpu_i)])
            |=> pending_o[s*NUM_CPU + int'($past(eoi_cpu_i))]); // R9

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (a_hit && rise_v[s] && (edge_t || src_enable_i[s]) && int'(ack_cpu_i) < NUM_CPU
             && src_target_i[s*NUM_CPU + int'(ack_cpu_i)])
            |=> pending_o[s*NUM_CPU + int'($past(ack_cpu_i))]); // R11
    end
endmodule

bind irq_line_pending irq_line_pending_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPU   (NUM_CPU),
    .CPU_W     (CPU_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pending_o    (pending_o),
    .src_enable_i (src_enable_i),
    .src_mode_i   (src_mode_i),
    .src_target_i (src_target_i),
    .ack_valid_i  (ack_valid_i),
    .ack_cpu_i    (ack_cpu_i),
    .ack_id_i     (ack_id_i),
    .eoi_valid_i  (eoi_valid_i),
    .eoi_cpu_i    (eoi_cpu_i),
    .eoi_id_i     (eoi_id_i),
    .level_q      (level_q),
    .rise_v       (rise_v),
    .fall_v       (fall_v)
);

// File: tb/irq_line_pending_bench.sv
module irq_line_pending_bench;
    import irq_line_pending_pkg::*;

    localparam int NL = 16;
    localparam int NC = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [NL-1:0]       line = '0;
    logic [NL-1:0]       en   = '0;
    logic [2*NL-1:0]     mode = '0;
    logic [NL*NC-1:0]    tgt  = '0;
    logic                ack_v = 1'b0;
    logic [CW-1:0]       ack_c = '0;
    logic [IRQ_ID_W-1:0] ack_id = '0;
    logic                eoi_v = 1'b0;
    logic [CW-1:0]       eoi_c = '0;
    logic [IRQ_ID_W-1:0] eoi_id = '0;
    logic [NL*NC-1:0]    pend;

    irq_line_pending #(.NUM_LINES(NL), .NUM_CPU(NC), .SYNC_STAGES(2)) u_irq_line_pending (
        .clk          (clk),
        .rst          (rst),
        .irq_line_i   (line),
        .src_enable_i (en),
        .src_mode_i   (mode),
        .src_target_i (tgt),
        .ack_valid_i  (ack_v),
        .ack_cpu_i    (ack_c),
        .ack_id_i     (ack_id),
        .eoi_valid_i  (eoi_v),
        .eoi_cpu_i    (eoi_c),
        .eoi_id_i     (eoi_id),
        .pending_o    (pend)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1 reset";

    // Behavioural reference: wire history queue, level and pending arrays
    bit          m_pend [NL][NC];
    bit          m_lvl  [NL];
    logic [NL-1:0] hist [$];

    always @(posedge clk) begin : ref_model
        logic [NL-1:0] seen;
        bit            nxt [NL][NC];
        int            a_src;
        int            e_src;
        if (rst) begin
            foreach (m_pend[s, c]) m_pend[s][c] = 1'b0;
            foreach (m_lvl[s]) m_lvl[s] = 1'b0;
            hist.delete();
        end else begin
            hist.push_back(line);
            if (hist.size() > 3) void'(hist.pop_front());
            seen  = (hist.size() == 3) ? hist[0] : '0;
            a_src = ack_v ? int'(ack_id) - EXT_ID_BASE : -1;
            e_src = eoi_v ? int'(eoi_id) - EXT_ID_BASE : -1;
            for (int s = 0; s < NL; s++) begin
                for (int c = 0; c < NC; c++) nxt[s][c] = m_pend[s][c];
                if (a_src == s) begin
                    if (mode[2*s]) begin
                        for (int c = 0; c < NC; c++) nxt[s][c] = 1'b0;
                    end else begin
                        nxt[s][ack_c] = 1'b0;
                    end
                end
                if (seen[s] && !m_lvl[s] && (mode[2*s+1] || en[s])) begin
                    for (int c = 0; c < NC; c++) if (tgt[s*NC+c]) nxt[s][c] = 1'b1;
                end
                if (e_src == s && !mode[2*s+1] && en[s] && m_lvl[s] && tgt[s*NC+eoi_c]) begin
                    nxt[s][eoi_c] = 1'b1;
                end
            end
            for (int s = 0; s < NL; s++) begin
                for (int c = 0; c < NC; c++) m_pend[s][c] = nxt[s][c];
                m_lvl[s] = seen[s];
            end
        end
    end

    function automatic logic [NL*NC-1:0] model_vec();
        logic [NL*NC-1:0] v;
        for (int s = 0; s < NL; s++)
            for (int c = 0; c < NC; c++) v[s*NC+c] = m_pend[s][c];
        return v;
    endfunction

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (pend !== model_vec()) begin
                errors++;
                $display("FAIL %s: pending_o actual %h expected %h", phase, pend, model_vec());
            end
        end
    end

    task automatic expect_slice(input string tag, input int src, input logic [NC-1:0] exp);
        checks++;
        if (pend[src*NC +: NC] !== exp) begin
            errors++;
            $display("FAIL %s: source %0d pending actual %b expected %b",
                     tag, src, pend[src*NC +: NC], exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack(input int cpu, input int id);
        ack_c = CW'(cpu); ack_id = IRQ_ID_W'(id); ack_v = 1'b1;
        @(negedge clk);
        ack_v = 1'b0;
    endtask

    task automatic do_eoi(input int cpu, input int id);
        eoi_c = CW'(cpu); eoi_id = IRQ_ID_W'(id); eoi_v = 1'b1;
        @(negedge clk);
        eoi_v = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R1
        if (pend !== '0) begin
            errors++;
            $display("FAIL R1: pending_o after reset actual %h expected 0", pend);
        end

        // R10 / R12 configuration: mode field {edge, model}
        mode[1:0] = 2'b10; en[0] = 1'b1; tgt[0*NC +: NC] = 4'b0011;  // edge, per-cpu
        mode[3:2] = 2'b01; en[1] = 1'b1; tgt[1*NC +: NC] = 4'b0101;  // level, single
        mode[5:4] = 2'b00; en[2] = 1'b0; tgt[2*NC +: NC] = 4'b1111;  // level, disabled
        mode[7:6] = 2'b10; en[3] = 1'b0; tgt[3*NC +: NC] = 4'b1000;  // edge, disabled
        mode[9:8] = 2'b10; en[4] = 1'b1; tgt[4*NC +: NC] = 4'b0001;  // edge
        tick(1);

        phase = "R2 sync latency";
        line[0] = 1'b1;
        tick(1); expect_slice("R2 edge k", 0, 4'b0000);
        tick(1); expect_slice("R2 edge k+1", 0, 4'b0000);
        tick(1); expect_slice("R2 R12 edge k+2", 0, 4'b0011);

        phase = "R4 R10 rise handling";
        line[2] = 1'b1; line[3] = 1'b1;
        tick(4);
        expect_slice("R4 disabled level", 2, 4'b0000);
        expect_slice("R10 edge disabled", 3, 4'b1000);

        phase = "R8 per-cpu ack";
        do_ack(0, 32);
        expect_slice("R8", 0, 4'b0010);

        phase = "R5 held level";
        tick(6);
        expect_slice("R5", 0, 4'b0010);

        phase = "R6 falling";
        line[0] = 1'b0;
        tick(4);
        expect_slice("R6", 0, 4'b0010);

        phase = "R7 single handler ack";
        line[1] = 1'b1;
        tick(4);
        expect_slice("R7 before", 1, 4'b0101);
        do_ack(2, 33);
        expect_slice("R7", 1, 4'b0000);

        phase = "R9 end-of-interrupt";
        do_eoi(0, 33);
        expect_slice("R9 repend", 1, 4'b0001);
        do_eoi(1, 33);
        expect_slice("R9 not target", 1, 4'b0001);
        do_ack(3, 35);
        expect_slice("R9 edge ack", 3, 4'b0000);
        do_eoi(3, 35);
        expect_slice("R9 edge no repend", 3, 4'b0000);
        line[1] = 1'b0;
        tick(4);
        do_ack(0, 33);
        do_eoi(0, 33);
        expect_slice("R9 low level", 1, 4'b0000);

        phase = "R3 id window";
        line[4] = 1'b1;
        tick(4);
        expect_slice("R3 set", 4, 4'b0001);
        do_ack(0, 31);
        do_ack(0, 48);
        do_ack(0, 4);
        do_ack(0, 1023);
        expect_slice("R3 out of window", 4, 4'b0001);
        do_ack(0, 36);
        expect_slice("R3 mapped", 4, 4'b0000);

        phase = "R11 set over clear";
        line[4] = 1'b0;
        tick(4);
        line[4] = 1'b1;
        tick(2);
        do_ack(0, 36);
        expect_slice("R11", 4, 4'b0001);
        do_ack(0, 36);
        expect_slice("R11 later clear", 4, 4'b0000);

        phase = "R4 R6 R7 R8 R9 R11 random mix";
        en = NL'($urandom); mode = $urandom; tgt = {$urandom, $urandom};
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 == 0) line[$urandom % NL] = ~line[$urandom % NL];
            ack_v  = ($urandom % 3 == 0);
            ack_c  = CW'($urandom);
            ack_id = IRQ_ID_W'(30 + $urandom % 20);
            eoi_v  = ($urandom % 3 == 0);
            eoi_c  = CW'($urandom);
            eoi_id = IRQ_ID_W'(30 + $urandom % 20);
            if (i % 500 == 499) begin
                en = NL'($urandom); mode = $urandom; tgt = {$urandom, $urandom};
            end
            @(negedge clk);
        end
        ack_v = 1'b0; eoi_v = 1'b0;
        tick(4);
        finish_run();
    end
endmodule